// File: doc/BRIEF.md
# Program Counter Trace Recorder

This block sits beside an instruction-issue stage. While tracing is armed, every instruction that is about to issue is held back for a moment while its program counter is written to a circular buffer in physical memory. Once memory has taken that store, the held instruction is allowed to proceed. The buffer is described by a base address and a two-halved pointer. The upper half of the pointer holds a negative count of the entries that remain. The lower half is an index into the buffer. After every recorded entry both halves advance by one. When the count half reaches zero, the pointer goes back to the value it was loaded with, so the buffer is refilled from its start.

A control load writes the base and the starting pointer and arms tracing. A disable pulse disarms tracing and leaves the base and pointer as they are. The next write location, which is the base plus the index half, is always visible on a status output. While the recorder's own store is outstanding, its trace-enable flag is low, so that activity is never captured.

Both streams use a valid/ready handshake. On the issue side, `issue_valid` with `issue_pc` must stay asserted and stable until the cycle in which `issue_ready` is high. While armed and idle, the recorder holds `issue_ready` low, emits a store, and raises `issue_ready` for exactly one cycle after the store is accepted. When not armed, `issue_ready` is high and the stream passes straight through. On the memory side, `mem_valid` with its address and data stays asserted and unchanged until `mem_ready` is sampled high. The block never has more than one store outstanding.

Top module: `pctr_trace`

## Requirements
- R1: After reset, tracing is disarmed (`trace_on` = 0), `issue_ready` = 1, `mem_valid` = 0 and `ctl_next_addr` = 0.
- R2: In the cycle after a `ctl_load` pulse, `ctl_next_addr` equals `ctl_base` plus the low H bits of `ctl_ptr` (zero-extended to W bits, full-width carry) and `trace_on` = 1.
- R3: When armed and idle with `issue_valid` high, `issue_ready` is 0 in that cycle. In the next cycle `mem_valid` is 1, with `mem_addr` equal to the `ctl_next_addr` of the capture cycle and `mem_data` equal to the captured `issue_pc`.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_data` hold, and `issue_ready` stays 0.
- R5: In the cycle after a store is accepted, `issue_ready` = 1, `mem_valid` = 0 and `trace_on` = 0. `trace_on` is also 0 throughout the store. It returns to 1 in the following cycle.
- R6: Each accepted store adds one to the index half (modulo 2^H) and one to the count half, so the next address moves by one word.
- R7: When the count half would become zero after a step, the whole pointer is instead restored to the last loaded starting value. A start count of −N therefore gives N entries per lap.
- R8: A `ctl_disable` pulse sets `trace_on` to 0 and leaves `ctl_next_addr` unchanged. While disarmed, instructions pass with `issue_ready` = 1 and no store is made.
- R9: The count half never enters the address. Two pointers with the same index but different counts give the same `ctl_next_addr` and `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_load | input | 1 | Load base and start pointer, then arm |
| ctl_base | input | W | Buffer base address (physical) |
| ctl_ptr | input | W | Start pointer: count half in upper H bits, index half in lower H bits |
| ctl_disable | input | 1 | Disarm tracing |
| ctl_next_addr | output | W | Base plus index: next store location |
| trace_on | output | 1 | Armed and not busy with its own store |
| issue_valid | input | 1 | Instruction ready to issue |
| issue_pc | input | W | Program counter of that instruction |
| issue_ready | output | 1 | Instruction may issue this cycle |
| mem_valid | output | 1 | Trace store request |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | W | Physical store address |
| mem_data | output | W | Stored program counter |

## Verification
The bench sweeps several start pointers of 1 to 4 entries. These include an index just below 2^18, so the index half rolls over, and a base whose low half is all ones, so the address add carries into the upper half. For each configuration it records more than two full laps, with a different number of memory stall cycles on each entry. If the design let the count carry into the index, or added the count half to the base, the addresses would jump. If it restored the wrong value at the wrap, or wrapped one entry early or late, the lap would begin at the wrong index. Dropping the stall would release the instruction before its store was taken. Leaving the flag set during the store, or letting a disable move the pointer, would show up on `trace_on` and `ctl_next_addr`.

// File: rtl/pctr_pkg.sv
package pctr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STORE   = 2'd1,
    ST_RELEASE = 2'd2
  } pctr_state_e;

endpackage

// File: rtl/pctr_ptr.sv
// Two-halved trace pointer: negative count (upper) and index (lower).
module pctr_ptr #(
  parameter int H = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*H-1:0] load_val,
  input  logic           step,
  output logic [H-1:0]   idx
);
  localparam int PW = 2 * H;

  logic [PW-1:0] start_q;
  logic [PW-1:0] ptr_q;
  logic [H-1:0]  cnt_inc;
  logic [H-1:0]  idx_inc;
  logic          lap_end;

  assign cnt_inc = ptr_q[PW-1:H] + 1'b1;
  assign idx_inc = ptr_q[H-1:0] + 1'b1;
  assign lap_end = (cnt_inc == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      ptr_q   <= '0;
    end else if (load) begin
      start_q <= load_val;
      ptr_q   <= load_val;
    end else if (step) begin
      if (lap_end) ptr_q <= start_q;
      else         ptr_q <= {cnt_inc, idx_inc};
    end
  end

  assign idx = ptr_q[H-1:0];

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !lap_end) |=> (ptr_q[H-1:0] == $past(ptr_q[H-1:0]) + 1'b1));

  // R7
  lap_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && lap_end) |=> (ptr_q == $past(start_q)));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr_q));

endmodule

// File: rtl/pctr_addr.sv
// Base register and store-address former (index half only).
module pctr_addr #(
  parameter int H = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*H-1:0] load_base,
  input  logic [H-1:0]   idx,
  output logic [2*H-1:0] addr
);
  localparam int W = 2 * H;

  logic [W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= load_base;
  end

  assign addr = base_q + {{(W-H){1'b0}}, idx};

  // R2
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (base_q == $past(load_base)));

endmodule

// File: rtl/pctr_ctrl.sv
// Arm flag, capture/store/release sequencing and issue stall.
module pctr_ctrl
  import pctr_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_load,
  input  logic         ctl_disable,
  input  logic [W-1:0] next_addr,
  input  logic         issue_valid,
  input  logic [W-1:0] issue_pc,
  output logic         issue_ready,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_data,
  output logic         step,
  output logic         trace_on
);
  pctr_state_e state_q, state_d;
  logic        armed_q;
  logic        capture;
  logic [W-1:0] addr_q, data_q;

  assign capture = (state_q == ST_IDLE) && armed_q && issue_valid;
  assign step    = (state_q == ST_STORE) && mem_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (capture) state_d = ST_STORE;
      ST_STORE:   if (mem_ready) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ctl_load)         armed_q <= 1'b1;
      else if (ctl_disable) armed_q <= 1'b0;
      if (capture) begin
        addr_q <= next_addr;
        data_q <= issue_pc;
      end
    end
  end

  assign mem_valid   = (state_q == ST_STORE);
  assign mem_addr    = addr_q;
  assign mem_data    = data_q;
  assign trace_on    = armed_q && (state_q == ST_IDLE);
  assign issue_ready = ((state_q == ST_IDLE) && !armed_q) || (state_q == ST_RELEASE);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && armed_q && issue_valid)
      |=> (mem_valid && mem_addr == $past(next_addr) && mem_data == $past(issue_pc)));

  // R3
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !issue_ready);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (issue_ready && !mem_valid && !trace_on));

  // R5
  self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !trace_on);

endmodule

// File: rtl/pctr_trace.sv
// Program counter trace recorder top.
module pctr_trace #(
  parameter int H = 18,
  localparam int W = 2 * H
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_load,
  input  logic [W-1:0] ctl_base,
  input  logic [W-1:0] ctl_ptr,
  input  logic         ctl_disable,
  output logic [W-1:0] ctl_next_addr,
  output logic         trace_on,
  input  logic         issue_valid,
  input  logic [W-1:0] issue_pc,
  output logic         issue_ready,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_data
);
  logic [H-1:0] idx;
  logic         step;

  pctr_ptr #(.H(H)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl_load),
    .load_val (ctl_ptr),
    .step     (step),
    .idx      (idx)
  );

  pctr_addr #(.H(H)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctl_load),
    .load_base (ctl_base),
    .idx       (idx),
    .addr      (ctl_next_addr)
  );

  pctr_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_load    (ctl_load),
    .ctl_disable (ctl_disable),
    .next_addr   (ctl_next_addr),
    .issue_valid (issue_valid),
    .issue_pc    (issue_pc),
    .issue_ready (issue_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .step        (step),
    .trace_on    (trace_on)
  );

  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_disable && !ctl_load) |=> !trace_on);

endmodule

// File: tb/pctr_trace_bench.sv
module pctr_trace_bench;
  localparam int H = 18;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_load = 1'b0, ctl_disable = 1'b0;
  logic [W-1:0] ctl_base = '0, ctl_ptr = '0;
  logic [W-1:0] ctl_next_addr;
  logic         trace_on;
  logic         issue_valid = 1'b0;
  logic [W-1:0] issue_pc = '0;
  logic         issue_ready;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [W-1:0] mem_addr, mem_data;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model
  logic [W-1:0] m_base;
  logic [H-1:0] m_cnt, m_idx;
  logic [W-1:0] m_start;
  bit           m_armed;

  always #2 clk = ~clk;

  pctr_trace #(.H(H)) u_pctr_trace (
    .clk(clk), .rst_n(rst_n),
    .ctl_load(ctl_load), .ctl_base(ctl_base), .ctl_ptr(ctl_ptr),
    .ctl_disable(ctl_disable), .ctl_next_addr(ctl_next_addr),
    .trace_on(trace_on),
    .issue_valid(issue_valid), .issue_pc(issue_pc), .issue_ready(issue_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_addr();
    return m_base + {{(W-H){1'b0}}, m_idx};
  endfunction

  task automatic do_load(input logic [W-1:0] base, input logic [W-1:0] ptr);
    @(negedge clk);
    ctl_load = 1'b1; ctl_base = base; ctl_ptr = ptr;
    @(negedge clk);
    ctl_load = 1'b0;
    m_base = base; m_start = ptr; m_cnt = ptr[W-1:H]; m_idx = ptr[H-1:0]; m_armed = 1'b1;
    chk("R2 next_addr after load", ctl_next_addr, exp_addr());
    chk("R2 trace_on after load", {35'd0, trace_on}, 36'd1);
  endtask

  task automatic do_instr(input logic [W-1:0] pc, input int stall);
    logic [W-1:0] ea;
    @(negedge clk);
    issue_valid = 1'b1; issue_pc = pc; mem_ready = 1'b0;
    if (!m_armed) begin
      chk("R8 pass-through ready", {35'd0, issue_ready}, 36'd1);
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R8 no store while disarmed", {35'd0, mem_valid}, 36'd0);
      return;
    end
    ea = exp_addr();
    chk("R3 stall on capture", {35'd0, issue_ready}, 36'd0);
    @(negedge clk);
    chk("R3 mem_valid", {35'd0, mem_valid}, 36'd1);
    chk("R3 R9 mem_addr", mem_addr, ea);
    chk("R3 mem_data", mem_data, pc);
    chk("R5 flag low in store", {35'd0, trace_on}, 36'd0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R4 valid held", {35'd0, mem_valid}, 36'd1);
      chk("R4 addr held", mem_addr, ea);
      chk("R4 still stalled", {35'd0, issue_ready}, 36'd0);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R5 release ready", {35'd0, issue_ready}, 36'd1);
    chk("R5 no second store", {35'd0, mem_valid}, 36'd0);
    chk("R5 flag low in release", {35'd0, trace_on}, 36'd0);
    m_cnt = m_cnt + 1'b1;
    m_idx = m_idx + 1'b1;
    if (m_cnt == '0) begin
      m_cnt = m_start[W-1:H]; m_idx = m_start[H-1:0];
      chk("R7 next_addr after lap restore", ctl_next_addr, exp_addr());
    end else begin
      chk("R6 next_addr after step", ctl_next_addr, exp_addr());
    end
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R5 flag back on", {35'd0, trace_on}, 36'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] bases [4];
    logic [H-1:0] idx0 [4];
    logic [H-1:0] cntv [4];
    bases[0] = 36'h0_0001_0000; idx0[0] = 18'h00000;
    bases[1] = 36'h0_0003_FFFF; idx0[1] = 18'h00001;
    bases[2] = 36'h1_2340_0000; idx0[2] = 18'h3FFFE;
    bases[3] = 36'h0_0000_0100; idx0[3] = 18'h3FFFF;
    m_armed = 1'b0; m_base = '0; m_cnt = '0; m_idx = '0; m_start = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 trace_on", {35'd0, trace_on}, 36'd0);
    chk("R1 issue_ready", {35'd0, issue_ready}, 36'd1);
    chk("R1 mem_valid", {35'd0, mem_valid}, 36'd0);
    chk("R1 next_addr", ctl_next_addr, 36'd0);
    do_instr(36'h0_0000_1000, 0);

    for (int c = 0; c < 4; c++) begin
      int n;
      n = c + 1;
      cntv[c] = -(18'(n));
      do_load(bases[c], {cntv[c], idx0[c]});
      for (int k = 0; k < 2 * n + 2; k++)
        do_instr(36'h5_0000_0000 + 36'(c * 64 + k * 4 + 1), k % 3);
    end

    // R9: same index, different count half -> same address
    do_load(36'h0_0000_4000, {18'h3FFF0, 18'h00010});
    begin
      logic [W-1:0] a1;
      a1 = ctl_next_addr;
      do_load(36'h0_0000_4000, {18'h3FFFE, 18'h00010});
      chk("R9 count half not in address", ctl_next_addr, a1);
    end
    do_instr(36'h7_7777_7777, 1);

    // R8: disable keeps pointer, stops capture
    begin
      logic [W-1:0] held;
      held = ctl_next_addr;
      @(negedge clk);
      ctl_disable = 1'b1;
      @(negedge clk);
      ctl_disable = 1'b0;
      m_armed = 1'b0;
      chk("R8 trace_on after disable", {35'd0, trace_on}, 36'd0);
      chk("R8 pointer kept", ctl_next_addr, held);
      do_instr(36'h0_0000_2000, 0);
      do_instr(36'h0_0000_2004, 0);
      chk("R8 pointer kept after passing instrs", ctl_next_addr, held);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule